// File: doc/BRIEF.md
# Operand Wakeup and Oldest-First Issue Queue

This block is the scheduling window that sits between rename and a single execution unit. Renamed instructions are written into free slots together with an opcode, a destination tag and two sources. Each source arrives either already holding its value or naming the tag of the instruction that will produce it. Entries wait in the window until every source is present. They then leave in whatever order their operands complete, not in program order.

Completed results come back on one broadcast bus that carries a tag and a value each cycle. Every waiting source whose tag equals the broadcast tag takes the value and becomes ready. Each cycle, a picker sends the oldest ready entry to the execution unit and frees its slot. When every slot is occupied, a full flag tells the front end to hold further allocations.

Top module: `wakeup_issue_queue`

## Requirements
- R1: While rst_ni is low and in the first cycle after it rises, issue_valid_o is 0 and full_o is 0.
- R2: When alloc_valid_i is 1 and full_o is 0 at a rising edge, the instruction is written into a free slot. It takes part in selection from the next cycle on.
- R3: A pending source (rdy input 0) whose tag equals bcast_tag_i while bcast_valid_i is 1 becomes ready at that edge and keeps bcast_val_i as its operand.
- R4: A pending source that matches a broadcast in the same cycle it is allocated captures that broadcast value, so no later broadcast is needed.
- R5: An entry is eligible only when both sources are ready. A source woken at an edge is eligible only from the following cycle, with no same-cycle bypass.
- R6: When several entries are eligible, the one allocated earliest among them is issued.
- R7: An issued entry is freed at the edge that ends its issue cycle and is never issued twice. A full window with an issue accepts allocation again in the next cycle.
- R8: full_o is 1 exactly when all 8 slots are occupied. An allocation presented while full_o is 1 is dropped and never reaches the issue port.
- R9: At most one entry issues per cycle. While issue_valid_o is 1, issue_op_o, issue_dst_o, issue_a_o and issue_b_o carry that entry's opcode, destination tag, first operand and second operand.
- R10: A broadcast does not alter a source that is already ready, at allocation or later, even when the tags are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_op_i | input | 8 | Opcode of the new entry |
| alloc_dst_i | input | 6 | Destination tag of the new entry |
| alloc_a_rdy_i | input | 1 | First source value already present |
| alloc_a_tag_i | input | 6 | Producer tag of the first source |
| alloc_a_val_i | input | 32 | First source value when present |
| alloc_b_rdy_i | input | 1 | Second source value already present |
| alloc_b_tag_i | input | 6 | Producer tag of the second source |
| alloc_b_val_i | input | 32 | Second source value when present |
| full_o | output | 1 | No free slot; allocation is held off |
| bcast_valid_i | input | 1 | Result broadcast valid |
| bcast_tag_i | input | 6 | Tag of the broadcast result |
| bcast_val_i | input | 32 | Broadcast result value |
| issue_valid_o | output | 1 | An entry issues this cycle |
| issue_op_o | output | 8 | Opcode of the issued entry |
| issue_dst_o | output | 6 | Destination tag of the issued entry |
| issue_a_o | output | 32 | First operand of the issued entry |
| issue_b_o | output | 32 | Second operand of the issued entry |

## Verification
Allocation and wakeup can happen in the same cycle. So can issue and allocation into the window that issue is emptying. The bench provokes the first case by allocating sources that name the tag on the bus in that very cycle, with both the pending and the already-ready source kinds. It provokes the second case by allocating while the window is full and an entry is issuing, and by random traffic that keeps it near full. A reference queue kept in allocation order judges each cycle: it predicts the issued entry, its operands and the full flag, so a capture that is lost or taken twice shows up as a wrong operand or a wrong issue order.

// File: rtl/sched_pkg.sv
package sched_pkg;
  parameter int unsigned TagW  = 6;
  parameter int unsigned DataW = 32;
  parameter int unsigned OpW   = 8;

  typedef logic [TagW-1:0]  tag_t;
  typedef logic [DataW-1:0] data_t;
  typedef logic [OpW-1:0]   op_t;

  typedef struct packed {
    logic  rdy;
    tag_t  tag;
    data_t val;
  } src_t;

  typedef struct packed {
    op_t  op;
    tag_t dst;
    src_t a;
    src_t b;
  } slot_t;

  // capture a broadcast into a still-pending source
  function automatic src_t snoop(src_t s, logic bv, tag_t bt, data_t bd);
    src_t r;
    r = s;
    if (!s.rdy && bv && (s.tag == bt)) begin
      r.rdy = 1'b1;
      r.val = bd;
    end
    return r;
  endfunction
endpackage

// File: rtl/free_pick.sv
module free_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] vld_i,
  output logic [N-1:0] pick_o,
  output logic         full_o
);
  logic found;

  always_comb begin
    pick_o = '0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!vld_i[i] && !found) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
    full_o = &vld_i;
  end
endmodule

// File: rtl/sched_slot.sv
module sched_slot
  import sched_pkg::*;
#(
  parameter int unsigned AgeW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  slot_t           wr_slot_i,
  input  logic            bc_v_i,
  input  tag_t            bc_tag_i,
  input  data_t           bc_val_i,
  input  logic            clr_i,
  input  logic            alloc_fire_i,
  input  logic            issue_fire_i,
  input  logic [AgeW-1:0] issue_age_i,
  output logic            vld_o,
  output logic            rdy_o,
  output logic [AgeW-1:0] age_o,
  output op_t             op_o,
  output tag_t            dst_o,
  output data_t           a_o,
  output data_t           b_o
);
  logic            vld_q;
  logic [AgeW-1:0] age_q, age_d;
  slot_t           slot_q;
  logic            older;

  // ages stay dense: new entry is 0, everyone shifts up on alloc,
  // entries older than the issued one shift down
  assign older = issue_fire_i && (age_q > issue_age_i);

  always_comb begin
    age_d = age_q;
    if (alloc_fire_i) age_d = age_d + AgeW'(1);
    if (older)        age_d = age_d - AgeW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      age_q  <= '0;
      slot_q <= '0;
    end else if (wr_i) begin
      vld_q      <= 1'b1;
      age_q      <= '0;
      slot_q.op  <= wr_slot_i.op;
      slot_q.dst <= wr_slot_i.dst;
      slot_q.a   <= snoop(wr_slot_i.a, bc_v_i, bc_tag_i, bc_val_i);
      slot_q.b   <= snoop(wr_slot_i.b, bc_v_i, bc_tag_i, bc_val_i);
    end else if (clr_i) begin
      vld_q <= 1'b0;
    end else if (vld_q) begin
      age_q    <= age_d;
      slot_q.a <= snoop(slot_q.a, bc_v_i, bc_tag_i, bc_val_i);
      slot_q.b <= snoop(slot_q.b, bc_v_i, bc_tag_i, bc_val_i);
    end
  end

  assign vld_o = vld_q;
  assign rdy_o = vld_q && slot_q.a.rdy && slot_q.b.rdy;
  assign age_o = age_q;
  assign op_o  = slot_q.op;
  assign dst_o = slot_q.dst;
  assign a_o   = slot_q.a.val;
  assign b_o   = slot_q.b.val;

  // R3
  a_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !clr_i && !slot_q.a.rdy && bc_v_i && (bc_tag_i == slot_q.a.tag)
    |=> slot_q.a.rdy && (slot_q.a.val == $past(bc_val_i)));

  // R10
  a_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !clr_i && slot_q.a.rdy |=> $stable(slot_q.a.val));

  // R10
  b_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_q && !clr_i && slot_q.b.rdy |=> $stable(slot_q.b.val));
endmodule

// File: rtl/oldest_pick.sv
module oldest_pick #(
  parameter int unsigned N    = 8,
  parameter int unsigned AgeW = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N-1:0]             rdy_i,
  input  logic [N-1:0][AgeW-1:0]   age_i,
  output logic [N-1:0]             gnt_o,
  output logic                     any_o
);
  logic [AgeW-1:0] best_age;

  always_comb begin
    gnt_o    = '0;
    any_o    = 1'b0;
    best_age = '0;
    for (int i = 0; i < N; i++) begin
      if (rdy_i[i] && (!any_o || age_i[i] > best_age)) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
        best_age = age_i[i];
        any_o    = 1'b1;
      end
    end
  end

  // R9
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R5
  grant_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~rdy_i) == '0);

  // R6
  grant_any_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_i != '0) |-> any_o);
endmodule

// File: rtl/wakeup_issue_queue.sv
module wakeup_issue_queue
  import sched_pkg::*;
#(
  parameter int unsigned Depth = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        alloc_valid_i,
  input  logic [7:0]  alloc_op_i,
  input  logic [5:0]  alloc_dst_i,
  input  logic        alloc_a_rdy_i,
  input  logic [5:0]  alloc_a_tag_i,
  input  logic [31:0] alloc_a_val_i,
  input  logic        alloc_b_rdy_i,
  input  logic [5:0]  alloc_b_tag_i,
  input  logic [31:0] alloc_b_val_i,
  output logic        full_o,
  input  logic        bcast_valid_i,
  input  logic [5:0]  bcast_tag_i,
  input  logic [31:0] bcast_val_i,
  output logic        issue_valid_o,
  output logic [7:0]  issue_op_o,
  output logic [5:0]  issue_dst_o,
  output logic [31:0] issue_a_o,
  output logic [31:0] issue_b_o
);
  localparam int unsigned AgeW = $clog2(Depth);
  localparam int unsigned CntW = AgeW + 1;

  logic [Depth-1:0]            vld, rdy, pick, wr, gnt;
  logic [Depth-1:0][AgeW-1:0]  age;
  op_t                         op   [Depth];
  tag_t                        dst  [Depth];
  data_t                       aval [Depth];
  data_t                       bval [Depth];
  logic                        alloc_fire;
  logic [AgeW-1:0]             issue_age;
  slot_t                       new_slot;
  logic [CntW-1:0]             cnt;

  assign new_slot.op    = alloc_op_i;
  assign new_slot.dst   = alloc_dst_i;
  assign new_slot.a.rdy = alloc_a_rdy_i;
  assign new_slot.a.tag = alloc_a_tag_i;
  assign new_slot.a.val = alloc_a_val_i;
  assign new_slot.b.rdy = alloc_b_rdy_i;
  assign new_slot.b.tag = alloc_b_tag_i;
  assign new_slot.b.val = alloc_b_val_i;

  free_pick #(.N(Depth)) u_free (
    .vld_i  (vld),
    .pick_o (pick),
    .full_o (full_o)
  );

  assign alloc_fire = alloc_valid_i && !full_o;
  assign wr         = alloc_fire ? pick : '0;

  for (genvar i = 0; i < Depth; i++) begin : g_slot
    sched_slot #(.AgeW(AgeW)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .wr_i         (wr[i]),
      .wr_slot_i    (new_slot),
      .bc_v_i       (bcast_valid_i),
      .bc_tag_i     (bcast_tag_i),
      .bc_val_i     (bcast_val_i),
      .clr_i        (gnt[i]),
      .alloc_fire_i (alloc_fire),
      .issue_fire_i (issue_valid_o),
      .issue_age_i  (issue_age),
      .vld_o        (vld[i]),
      .rdy_o        (rdy[i]),
      .age_o        (age[i]),
      .op_o         (op[i]),
      .dst_o        (dst[i]),
      .a_o          (aval[i]),
      .b_o          (bval[i])
    );
  end

  oldest_pick #(.N(Depth), .AgeW(AgeW)) u_sel (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rdy_i  (rdy),
    .age_i  (age),
    .gnt_o  (gnt),
    .any_o  (issue_valid_o)
  );

  always_comb begin
    issue_op_o  = '0;
    issue_dst_o = '0;
    issue_a_o   = '0;
    issue_b_o   = '0;
    issue_age   = '0;
    for (int i = 0; i < Depth; i++) begin
      if (gnt[i]) begin
        issue_op_o  = issue_op_o  | op[i];
        issue_dst_o = issue_dst_o | dst[i];
        issue_a_o   = issue_a_o   | aval[i];
        issue_b_o   = issue_b_o   | bval[i];
        issue_age   = issue_age   | age[i];
      end
    end
  end

  assign cnt = CntW'($countones(vld));

  // R2
  alloc_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_fire && !issue_valid_o |=> cnt == $past(cnt) + CntW'(1));

  // R7
  issue_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o && !alloc_fire |=> cnt == $past(cnt) - CntW'(1));

  // R8
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !issue_valid_o |=> full_o);

  // R8
  full_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o == (cnt == CntW'(Depth)));
endmodule

// File: tb/sim_wakeup_issue_queue.sv
`timescale 1ns/1ps
module sim_wakeup_issue_queue;
  localparam int Depth = 8;

  typedef struct {
    logic [7:0]  op;
    logic [5:0]  dst;
    logic        ar;
    logic [5:0]  at;
    logic [31:0] ad;
    logic        br;
    logic [5:0]  bt;
    logic [31:0] bd;
  } ent_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        alloc_valid_i = 1'b0;
  logic [7:0]  alloc_op_i = '0;
  logic [5:0]  alloc_dst_i = '0;
  logic        alloc_a_rdy_i = 1'b0;
  logic [5:0]  alloc_a_tag_i = '0;
  logic [31:0] alloc_a_val_i = '0;
  logic        alloc_b_rdy_i = 1'b0;
  logic [5:0]  alloc_b_tag_i = '0;
  logic [31:0] alloc_b_val_i = '0;
  logic        full_o;
  logic        bcast_valid_i = 1'b0;
  logic [5:0]  bcast_tag_i = '0;
  logic [31:0] bcast_val_i = '0;
  logic        issue_valid_o;
  logic [7:0]  issue_op_o;
  logic [5:0]  issue_dst_o;
  logic [31:0] issue_a_o;
  logic [31:0] issue_b_o;

  int   errors = 0;
  int   checks = 0;
  bit   done   = 0;
  ent_t q[$];
  string req = "R1";

  always #2 clk = ~clk;

  wakeup_issue_queue #(.Depth(Depth)) u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(alloc_valid_i), .alloc_op_i(alloc_op_i), .alloc_dst_i(alloc_dst_i),
    .alloc_a_rdy_i(alloc_a_rdy_i), .alloc_a_tag_i(alloc_a_tag_i), .alloc_a_val_i(alloc_a_val_i),
    .alloc_b_rdy_i(alloc_b_rdy_i), .alloc_b_tag_i(alloc_b_tag_i), .alloc_b_val_i(alloc_b_val_i),
    .full_o(full_o),
    .bcast_valid_i(bcast_valid_i), .bcast_tag_i(bcast_tag_i), .bcast_val_i(bcast_val_i),
    .issue_valid_o(issue_valid_o), .issue_op_o(issue_op_o), .issue_dst_o(issue_dst_o),
    .issue_a_o(issue_a_o), .issue_b_o(issue_b_o)
  );

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  function automatic int oldest_ready();
    for (int i = 0; i < q.size(); i++)
      if (q[i].ar && q[i].br) return i;
    return -1;
  endfunction

  function automatic ent_t snoop_m(ent_t e, logic bv, logic [5:0] bt, logic [31:0] bd);
    ent_t r = e;
    if (bv && !r.ar && r.at == bt) begin r.ar = 1'b1; r.ad = bd; end
    if (bv && !r.br && r.bt == bt) begin r.br = 1'b1; r.bd = bd; end
    return r;
  endfunction

  // one cycle: drive at negedge, check state-derived outputs, advance model
  task automatic step(input logic av, input ent_t e,
                      input logic bv, input logic [5:0] bt, input logic [31:0] bd);
    int k;
    bit was_full;
    @(negedge clk);
    alloc_valid_i = av;
    alloc_op_i = e.op;  alloc_dst_i = e.dst;
    alloc_a_rdy_i = e.ar; alloc_a_tag_i = e.at; alloc_a_val_i = e.ad;
    alloc_b_rdy_i = e.br; alloc_b_tag_i = e.bt; alloc_b_val_i = e.bd;
    bcast_valid_i = bv; bcast_tag_i = bt; bcast_val_i = bd;
    #1;
    k = oldest_ready();
    was_full = (q.size() == Depth);
    chk("R8", "full", 64'(full_o), 64'(was_full));
    chk(req, "issue_valid", 64'(issue_valid_o), 64'(k >= 0));
    if (k >= 0 && issue_valid_o) begin
      chk(req, "issue_op",  64'(issue_op_o),  64'(q[k].op));
      chk(req, "issue_dst", 64'(issue_dst_o), 64'(q[k].dst));
      chk(req, "issue_a",   64'(issue_a_o),   64'(q[k].ad));
      chk(req, "issue_b",   64'(issue_b_o),   64'(q[k].bd));
    end
    if (k >= 0) q.delete(k);
    foreach (q[i]) q[i] = snoop_m(q[i], bv, bt, bd);
    if (av && !was_full) q.push_back(snoop_m(e, bv, bt, bd));
  endtask

  function automatic ent_t mk(logic [7:0] op, logic [5:0] dst,
                              logic ar, logic [5:0] at, logic [31:0] ad,
                              logic br, logic [5:0] bt, logic [31:0] bd);
    ent_t e;
    e.op = op; e.dst = dst; e.ar = ar; e.at = at; e.ad = ad;
    e.br = br; e.bt = bt; e.bd = bd;
    return e;
  endfunction

  task automatic idle(int n);
    ent_t z = mk(0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < n; i++) step(1'b0, z, 1'b0, 6'd0, 32'd0);
  endtask

  initial begin : watchdog
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    ent_t z;
    int unsigned seed;
    z = mk(0, 0, 0, 0, 0, 0, 0, 0);
    seed = $urandom(32'd1357);

    // R1 reset state
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "issue_valid in reset", 64'(issue_valid_o), 64'd0);
    chk("R1", "full in reset", 64'(full_o), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    req = "R1";
    idle(2);

    // R4 pending source caught by broadcast in allocation cycle
    req = "R4";
    step(1'b1, mk(8'h11, 6'd1, 1'b0, 6'd5, 32'd0, 1'b1, 6'd0, 32'h0000_0B0B),
         1'b1, 6'd5, 32'hCAFE_0005);
    idle(2);

    // R5 wakeup makes entry eligible only in the following cycle
    req = "R5";
    step(1'b1, mk(8'h22, 6'd2, 1'b0, 6'd9, 32'd0, 1'b0, 6'd10, 32'd0), 1'b0, 6'd0, 32'd0);
    step(1'b0, z, 1'b1, 6'd9, 32'h0000_0909);
    step(1'b0, z, 1'b1, 6'd10, 32'h0000_1010);
    idle(2);

    // R3 both sources captured from separate broadcasts
    req = "R3";
    step(1'b1, mk(8'h33, 6'd3, 1'b0, 6'd14, 32'd0, 1'b0, 6'd15, 32'd0), 1'b0, 6'd0, 32'd0);
    step(1'b0, z, 1'b1, 6'd15, 32'h1515_1515);
    step(1'b0, z, 1'b1, 6'd14, 32'h1414_1414);
    idle(2);

    // R6 entries woken together leave oldest first
    req = "R6";
    for (int i = 0; i < 3; i++)
      step(1'b1, mk(8'(8'h40 + i), 6'(20 + i), 1'b0, 6'd12, 32'd0, 1'b1, 6'd0, 32'(i)),
           1'b0, 6'd0, 32'd0);
    step(1'b0, z, 1'b1, 6'd12, 32'h0000_1212);
    idle(4);

    // R8 fill, drop allocation while full; R7 reuse after issue
    req = "R8";
    for (int i = 0; i < Depth; i++)
      step(1'b1, mk(8'(8'h50 + i), 6'(24 + i), 1'b0, 6'd40, 32'd0, 1'b1, 6'd0, 32'(i)),
           1'b0, 6'd0, 32'd0);
    step(1'b1, mk(8'hEE, 6'd63, 1'b1, 6'd0, 32'hDEAD, 1'b1, 6'd0, 32'hBEEF), 1'b0, 6'd0, 32'd0);
    step(1'b0, z, 1'b1, 6'd40, 32'h0000_4040);
    req = "R7";
    // full with issue in progress: allocation refused this cycle, accepted next
    step(1'b1, mk(8'h66, 6'd44, 1'b1, 6'd0, 32'h66, 1'b1, 6'd0, 32'h67), 1'b0, 6'd0, 32'd0);
    step(1'b1, mk(8'h77, 6'd45, 1'b1, 6'd0, 32'h77, 1'b1, 6'd0, 32'h78), 1'b0, 6'd0, 32'd0);
    idle(Depth + 3);

    // R10 ready source untouched by equal-tag broadcasts
    req = "R10";
    step(1'b1, mk(8'h88, 6'd50, 1'b1, 6'd30, 32'hAAAA_AAAA, 1'b0, 6'd31, 32'd0),
         1'b1, 6'd30, 32'h1234_5678);
    step(1'b0, z, 1'b1, 6'd30, 32'h5555_5555);
    step(1'b0, z, 1'b1, 6'd31, 32'h3131_3131);
    idle(2);

    // R9 mixed random traffic, broadcast tags from a small pool
    req = "R9";
    for (int n = 0; n < 3000; n++) begin
      ent_t e;
      logic av, bv;
      av = ($urandom % 100) < 55;
      bv = ($urandom % 100) < 60;
      e = mk(8'($urandom), 6'($urandom),
             ($urandom % 100) < 30, 6'($urandom % 8), $urandom,
             ($urandom % 100) < 30, 6'($urandom % 8), $urandom);
      if (!e.ar) e.ad = 32'd0;
      if (!e.br) e.bd = 32'd0;
      step(av, e, bv, 6'($urandom % 8), $urandom);
    end
    for (int t = 0; t < 8; t++) step(1'b0, z, 1'b1, 6'(t), 32'(t * 3));
    idle(Depth + 2);
    req = "R2";
    chk("R2", "window drained", 64'(issue_valid_o), 64'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule